// File: doc/BRIEF.md
# Auto-Increment Control Register File

A small bank of byte-wide control registers that a serial host programs over a byte-level bus. A serial slave front end, for example an I2C target, handles line timing and the device address. It hands this block start and stop markers, a strobe for each byte received, a strobe for each byte it wants to send back, and a strobe for each acknowledge it gets from the host. The contents of the registers drive the rest of the chip through a flat output vector.

After a start marker, the first received byte loads a 5-bit address pointer. Every later byte in the same burst is written to the location the pointer names, and the pointer then moves on by one. After location 06h the pointer wraps back to 00h. Only locations 00h to 06h exist. A byte aimed at any other location is still acknowledged, but it is thrown away. A stop marker ends the burst and keeps the pointer, so a later read starts at the place where the write left off. A read returns the register at the pointer, and the pointer advances only when the host acknowledges that byte. A synchronous active-high reset or an active-low power-down input puts every register back to its default value and clears the pointer.

Top module: `auto_inc_regfile`

## Requirements
- R1: After `rst`, the registers hold 00h=80h, 01h=20h, 02h=00h, 03h=10h, 04h=10h, 05h=10h and 06h=00h. Register n sits in `ctrl_regs[8n+7:8n]`. `ack` and `rd_valid` are low.
- R2: The first `rx_valid` byte after `bus_start` loads the pointer from `rx_data[4:0]`. This byte changes no register, and `ack` is high for the single cycle after it.
- R3: Each `rx_valid` byte after the pointer byte, and before `bus_stop` or another `bus_start`, is written to the register at the pointer. `ack` is high for the single cycle after each such byte, and no register changes in a cycle without `rx_valid`.
- R4: The pointer advances by one after each data byte and after each `rd_ack` pulse. A byte on `rx_valid` takes priority over `rd_ack` in the same cycle.
- R5: The pointer moves to 00h from 06h, and from any value of 06h or above, for both writes and reads.
- R6: A data byte sent while the pointer is 07h to 1Fh is acknowledged, changes no register, and still advances the pointer.
- R7: A `rd_req` pulse returns the register at the pointer on `rd_data`, with `rd_valid` high in the next cycle. The value is 00h when the pointer is 07h or above. `rd_req` alone does not move the pointer.
- R8: After `bus_stop`, received bytes are ignored and get no `ack` until the next `bus_start`. The pointer is kept across the stop and the following start.
- R9: When `pdn_n` is low at a clock edge, all registers return to their R1 defaults, the pointer returns to 00h and any burst ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_n | input | 1 | Active-low power-down that restores the defaults (synchronous) |
| bus_start | input | 1 | Start or repeated-start marker from the front end |
| bus_stop | input | 1 | Stop marker from the front end |
| rx_valid | input | 1 | A received byte is present on rx_data |
| rx_data | input | 8 | Received byte |
| rd_req | input | 1 | Front end requests the byte to transmit |
| rd_ack | input | 1 | Host acknowledged the transmitted byte |
| ack | output | 1 | Acknowledge for the byte received in the previous cycle |
| rd_valid | output | 1 | rd_data holds the requested byte |
| rd_data | output | 8 | Byte returned for a read |
| ctrl_regs | output | 56 | All register contents, register n in bits 8n+7:8n |

## Verification
The assertions check on every cycle that `ack` and `rd_valid` only follow their strobes, and that the registers stay unchanged without a received byte. They also check that power-down lands exactly on the defaults, that an out-of-range read returns zero, and that an advance from 06h goes to 00h. The bench scenarios are needed to show the ordering effects. These are the pointer byte against the data bytes, the write wrap across a burst, the discarded out-of-range writes, the pointer kept across a stop, and the rule that a read advances only on the host's acknowledge.

// File: rtl/auto_inc_regfile_pkg.sv
package auto_inc_regfile_pkg;

    localparam int NUM_REGS = 7;
    localparam int DW       = 8;
    localparam int AW       = 5;
    localparam int FLAT_W   = NUM_REGS * DW;

    typedef logic [AW-1:0] ptr_t;
    typedef logic [DW-1:0] byte_t;

    localparam ptr_t LAST_IDX = ptr_t'(NUM_REGS - 1);
    localparam ptr_t NUM_IDX  = ptr_t'(NUM_REGS);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PTR  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic  en;
        ptr_t  addr;
        byte_t data;
    } wr_req_t;

    function automatic byte_t reg_default(input int unsigned idx);
        byte_t v;
        case (idx)
            0:       v = byte_t'(8'h80);
            1:       v = byte_t'(8'h20);
            3, 4, 5: v = byte_t'(8'h10);
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [FLAT_W-1:0] all_defaults();
        logic [FLAT_W-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            v[i*DW +: DW] = reg_default(i);
        end
        return v;
    endfunction

    // Advance with wrap: anything at or past the last register goes to 0
    function automatic ptr_t ptr_next(input ptr_t p);
        return (p >= LAST_IDX) ? '0 : ptr_t'(p + ptr_t'(1));
    endfunction

endpackage

// File: rtl/cr_seq.sv
module cr_seq
    import auto_inc_regfile_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    pdn_n,
    input  logic    bus_start,
    input  logic    bus_stop,
    input  logic    rx_valid,
    input  byte_t   rx_data,
    input  logic    rd_ack,
    output ptr_t    ptr_q,
    output wr_req_t wr,
    output logic    ack_q
);

    phase_e phase_q;
    logic   byte_live;

    // A byte counts only when no start/stop marker shares its cycle
    assign byte_live = rx_valid && !bus_start && !bus_stop;

    always_ff @(posedge clk) begin
        if (rst || !pdn_n) begin
            phase_q <= PH_IDLE;
            ptr_q   <= '0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (bus_start) begin
                phase_q <= PH_PTR;
            end else if (bus_stop) begin
                phase_q <= PH_IDLE;
            end else if (rx_valid) begin
                case (phase_q)
                    PH_PTR: begin
                        ptr_q   <= rx_data[AW-1:0];
                        phase_q <= PH_DATA;
                        ack_q   <= 1'b1;
                    end
                    PH_DATA: begin
                        ptr_q <= ptr_next(ptr_q);
                        ack_q <= 1'b1;
                    end
                    default: ;
                endcase
            end else if (rd_ack) begin
                ptr_q <= ptr_next(ptr_q);
            end
        end
    end

    always_comb begin
        wr.en   = byte_live && (phase_q == PH_DATA) && (ptr_q < NUM_IDX);
        wr.addr = ptr_q;
        wr.data = rx_data;
    end

endmodule

// File: rtl/cr_bank.sv
module cr_bank
    import auto_inc_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pdn_n,
    input  wr_req_t           wr,
    output logic [FLAT_W-1:0] regs_o
);

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_reg
            byte_t q_r;
            always_ff @(posedge clk) begin
                if (rst || !pdn_n) begin
                    q_r <= reg_default(g);
                end else if (wr.en && (wr.addr == ptr_t'(g))) begin
                    q_r <= wr.data;
                end
            end
            assign regs_o[g*DW +: DW] = q_r;
        end
    endgenerate

endmodule

// File: rtl/cr_readout.sv
module cr_readout
    import auto_inc_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pdn_n,
    input  logic              rd_req,
    input  ptr_t              ptr,
    input  logic [FLAT_W-1:0] regs,
    output logic              rd_valid,
    output byte_t             rd_data
);

    byte_t sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (ptr == ptr_t'(i)) sel = regs[i*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pdn_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= sel;
        end
    end

endmodule

// File: rtl/auto_inc_regfile.sv
module auto_inc_regfile
    import auto_inc_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pdn_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              rx_valid,
    input  logic [DW-1:0]     rx_data,
    input  logic              rd_req,
    input  logic              rd_ack,
    output logic              ack,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic [FLAT_W-1:0] ctrl_regs
);

    ptr_t    ptr_q;
    wr_req_t wr;

    cr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .pdn_n     (pdn_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rd_ack    (rd_ack),
        .ptr_q     (ptr_q),
        .wr        (wr),
        .ack_q     (ack)
    );

    cr_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .pdn_n  (pdn_n),
        .wr     (wr),
        .regs_o (ctrl_regs)
    );

    cr_readout u_rd (
        .clk      (clk),
        .rst      (rst),
        .pdn_n    (pdn_n),
        .rd_req   (rd_req),
        .ptr      (ptr_q),
        .regs     (ctrl_regs),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/auto_inc_regfile_chk.sv
module auto_inc_regfile_chk
    import auto_inc_regfile_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pdn_n,
    input logic              rx_valid,
    input logic              rd_req,
    input logic              ack,
    input logic              rd_valid,
    input logic [DW-1:0]     rd_data,
    input logic [FLAT_W-1:0] ctrl_regs,
    input ptr_t              ptr_q
);

    // R3
    ack_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(rx_valid));

    // R3
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pdn_n && !rx_valid) |=> $stable(ctrl_regs));

    // R7
    rd_valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_req));

    // R7
    rd_invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && ($past(ptr_q) >= NUM_IDX)) |-> (rd_data == '0));

    // R5
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(ptr_q) == LAST_IDX) && (ptr_q != $past(ptr_q)) && !$past(rx_valid))
            |-> (ptr_q == '0));

    // R9
    pdn_defaults_chk: assert property (@(posedge clk) disable iff (rst)
        !pdn_n |=> (ctrl_regs == all_defaults()));

endmodule

bind auto_inc_regfile auto_inc_regfile_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pdn_n     (pdn_n),
    .rx_valid  (rx_valid),
    .rd_req    (rd_req),
    .ack       (ack),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .ctrl_regs (ctrl_regs),
    .ptr_q     (ptr_q)
);

// File: tb/sim_auto_inc_regfile.sv
`timescale 1ns/1ps
module sim_auto_inc_regfile;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pdn_n = 1'b1;
    logic        bus_start = 1'b0;
    logic        bus_stop = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rd_req = 1'b0;
    logic        rd_ack = 1'b0;
    logic        ack;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [55:0] ctrl_regs;

    always #4 clk = ~clk;

    auto_inc_regfile u0 (
        .clk(clk), .rst(rst), .pdn_n(pdn_n), .bus_start(bus_start),
        .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_data(rx_data),
        .rd_req(rd_req), .rd_ack(rd_ack), .ack(ack), .rd_valid(rd_valid),
        .rd_data(rd_data), .ctrl_regs(ctrl_regs)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [7:0] mreg [7];
    int mptr;
    int mphase;
    logic [7:0] exp_q [$];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int adv(input int p);
        return (p >= 6) ? 0 : p + 1;
    endfunction

    task automatic model_defaults();
        mreg[0] = 8'h80; mreg[1] = 8'h20; mreg[2] = 8'h00;
        mreg[3] = 8'h10; mreg[4] = 8'h10; mreg[5] = 8'h10; mreg[6] = 8'h00;
        mptr = 0;
        mphase = 0;
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < 7; i++) chk(tag, int'(ctrl_regs[i*8 +: 8]), int'(mreg[i]));
    endtask

    task automatic do_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
        mphase = 1;
    endtask

    task automatic do_stop();
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
        mphase = 0;
    endtask

    task automatic send_byte(input string tag, input logic [7:0] d);
        int exp_ack;
        exp_ack = 0;
        if (mphase == 1) begin
            mptr = int'(d[4:0]);
            mphase = 2;
            exp_ack = 1;
        end else if (mphase == 2) begin
            if (mptr < 7) mreg[mptr] = d;
            mptr = adv(mptr);
            exp_ack = 1;
        end
        @(negedge clk) begin rx_valid = 1'b1; rx_data = d; end
        @(negedge clk) rx_valid = 1'b0;
        chk(tag, int'(ack), exp_ack);
    endtask

    task automatic rd_byte();
        @(negedge clk) rd_req = 1'b1;
        exp_q.push_back((mptr < 7) ? mreg[mptr] : 8'h00);
        @(negedge clk) rd_req = 1'b0;
    endtask

    task automatic host_ack();
        @(negedge clk) rd_ack = 1'b1;
        mptr = adv(mptr);
        @(negedge clk) rd_ack = 1'b0;
    endtask

    // Monitor: pops expected read bytes as the design returns them
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected rd_valid", 1, 0);
            end else begin
                chk("R7 read data", int'(rd_data), int'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_defaults();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_regs("R1 defaults");
        chk("R1 ack idle", int'(ack), 0);
        chk("R1 rd_valid idle", int'(rd_valid), 0);

        // R2/R3: pointer byte then burst writes
        do_start();
        send_byte("R2 pointer ack", 8'h02);
        check_regs("R2 pointer byte writes nothing");
        send_byte("R3 data ack", 8'hAA);
        send_byte("R3 data ack", 8'hBB);
        do_stop();
        check_regs("R3 burst write");

        // R5 write wrap across 06h
        do_start();
        send_byte("R2 pointer ack", 8'h05);
        send_byte("R5 ack", 8'h11);
        send_byte("R5 ack", 8'h22);
        send_byte("R5 ack", 8'h33);
        send_byte("R5 ack", 8'h44);
        do_stop();
        check_regs("R5 wrap write");

        // R6 out-of-range write discarded, pointer wraps to 00h
        do_start();
        send_byte("R2 pointer ack", 8'h1A);
        send_byte("R6 discarded byte ack", 8'h55);
        check_regs("R6 no change");
        send_byte("R6 ack after wrap", 8'h66);
        do_stop();
        check_regs("R6 next byte lands at 00h");

        // R8 stop keeps pointer, bytes after stop ignored
        do_start();
        send_byte("R2 pointer ack", 8'h03);
        send_byte("R4 ack", 8'h77);
        do_stop();
        send_byte("R8 no ack after stop", 8'hEE);
        check_regs("R8 ignored byte");
        do_start();
        rd_byte();        // R8 pointer kept: reads 04h
        rd_byte();        // R7 no advance without ack
        host_ack();       // R4 advance on ack
        rd_byte();
        host_ack();
        rd_byte();        // 06h
        host_ack();       // R5 wrap on read
        rd_byte();        // 00h
        do_stop();

        // R7 out-of-range read returns 00h
        do_start();
        send_byte("R2 pointer ack", 8'h10);
        do_stop();
        rd_byte();

        // R9 power-down restores defaults and pointer
        @(negedge clk) pdn_n = 1'b0;
        @(negedge clk) pdn_n = 1'b1;
        model_defaults();
        check_regs("R9 power-down defaults");
        rd_byte();
        send_byte("R9 burst ended, no ack", 8'h99);
        check_regs("R9 byte ignored after power-down");

        repeat (3) @(negedge clk);
        chk("R7 all reads returned", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule